// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked system use a 64K x 8 asynchronous static RAM. The host presents a request (valid, write flag, 16-bit address, 8-bit write data) and the controller accepts it only while `req_ready` is high. It then plays out a fixed sequence of phases on the RAM pins, using a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable and a bidirectional data bus. When the sequence ends, `rsp_done` pulses for one cycle, and after a read `rsp_rdata` holds the byte captured from the RAM.

Every phase lasts a whole number of clock cycles. That number comes from a required time in nanoseconds divided by the clock period given as a parameter, rounded up, with a floor of one cycle. A second parameter selects between two speed grades of RAM timing. Between transactions the RAM stays deselected, with both strobes high and the data driver off.

Top module: `async_sram_ctrl`

## Requirements
- R1: While and just after synchronous reset (`rst` high), `req_ready`=1, `rsp_done`=0, `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1 and `mem_we_n`=1, and the controller does not drive `mem_dq`.
- R2: In every cycle where `req_ready` is high, the RAM is deselected (`mem_sel_n`=1, `mem_sel`=0) and both `mem_oe_n` and `mem_we_n` are high.
- R3: The two selects always change together. `mem_sel_n` is low exactly when `mem_sel` is high.
- R4: A read (`req_write`=0) asserts both selects and `mem_oe_n` low, with `mem_we_n` high, for RA = max(c(t_aa), c(t_oe)) cycles. The byte on `mem_dq` at the last clock edge of that phase is returned on `rsp_rdata`.
- R5: After the access phase of a read, the RAM is deselected with `mem_oe_n` high for RT = max(c(t_hz), c(t_ohz), c(t_rc) - RA) cycles. `rsp_done` rises RA+RT cycles after the accepting edge.
- R6: A write (`req_write`=1) first spends one cycle with the selects active and both strobes high. It then holds `mem_we_n` low for WP = max(c(t_wp), c(t_dw), c(t_aw)-1, c(t_cw)-1) cycles. Address and data stay constant across the whole low window, and the RAM then holds the written byte.
- R7: After the write strobe rises, the RAM stays deselected for WR = max(c(t_wr), c(t_wc) - 1 - WP) cycles. `rsp_done` rises 1+WP+WR cycles after the accepting edge.
- R8: The controller drives `mem_dq` only while `mem_oe_n` is high. It starts at the write setup phase and stops at the clock edge where `mem_we_n` rises. After a read, it waits until the full turn-off interval of R5 has passed.
- R9: A request is accepted only at a clock edge where both `req_valid` and `req_ready` are high. Requests raised while busy have no effect. `rsp_done` is high for exactly one cycle per transaction.
- R10: Here c(t) = ceil(t / CLK_NS), with a minimum of 1. With `SPEED_GRADE`=0 the times in ns are rc 85, aa 85, oe 45, hz 30, ohz 20, wc 85, cw 70, aw 70, wp 60, dw 35, as 0, wr 0. With `SPEED_GRADE`=1 they are rc 100, aa 100, oe 50, wc 100, cw 80, aw 80, wp 70, dw 40, and the others are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request may be accepted |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq | inout | DATA_W | Bidirectional RAM data bus |

## Verification
The assertions assume the RAM drives `mem_dq` only while it is selected with output enable low and write enable high. They also assume the host holds its request fields steady from raising `req_valid` until the accepting edge. The bench's RAM model follows the first rule and returns wrong data until the access count has elapsed. The host tasks change request fields only at falling edges and keep them unchanged until `req_ready` has been seen.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSET = 3'd1,
    PH_WSTB = 3'd2,
    PH_WREC = 3'd3,
    PH_RACC = 3'd4,
    PH_RTRN = 3'd5
  } phase_e;

  typedef enum int {
    TM_RC, TM_AA, TM_OE, TM_HZ, TM_OHZ,
    TM_WC, TM_CW, TM_AW, TM_WP, TM_DW, TM_AS, TM_WR
  } tm_e;

  // Required time in ns for a grade (0: faster part, 1: slower part)
  function automatic int tm_ns(input int grade, input tm_e item);
    int v;
    case (item)
      TM_RC:   v = (grade != 0) ? 100 : 85;
      TM_AA:   v = (grade != 0) ? 100 : 85;
      TM_OE:   v = (grade != 0) ? 50  : 45;
      TM_HZ:   v = 30;
      TM_OHZ:  v = 20;
      TM_WC:   v = (grade != 0) ? 100 : 85;
      TM_CW:   v = (grade != 0) ? 80  : 70;
      TM_AW:   v = (grade != 0) ? 80  : 70;
      TM_WP:   v = (grade != 0) ? 70  : 60;
      TM_DW:   v = (grade != 0) ? 40  : 35;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ceil(ns / period), never below one cycle
  function automatic int ns_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int tcyc(input int grade, input int period, input tm_e item);
    return ns_cyc(tm_ns(grade, item), period);
  endfunction

  function automatic int rd_acc_len(input int grade, input int period);
    return imax(tcyc(grade, period, TM_AA), tcyc(grade, period, TM_OE));
  endfunction

  function automatic int rd_trn_len(input int grade, input int period);
    int a;
    a = rd_acc_len(grade, period);
    return imax(imax(tcyc(grade, period, TM_HZ), tcyc(grade, period, TM_OHZ)),
                tcyc(grade, period, TM_RC) - a);
  endfunction

  function automatic int wr_set_len(input int grade, input int period);
    return tcyc(grade, period, TM_AS);
  endfunction

  function automatic int wr_stb_len(input int grade, input int period);
    int s;
    s = wr_set_len(grade, period);
    return imax(imax(tcyc(grade, period, TM_WP), tcyc(grade, period, TM_DW)),
                imax(tcyc(grade, period, TM_AW) - s, tcyc(grade, period, TM_CW) - s));
  endfunction

  function automatic int wr_rec_len(input int grade, input int period);
    return imax(tcyc(grade, period, TM_WR),
                tcyc(grade, period, TM_WC) - wr_set_len(grade, period)
                - wr_stb_len(grade, period));
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LEN_WSET = 1,
  parameter int LEN_WSTB = 6,
  parameter int LEN_WREC = 2,
  parameter int LEN_RACC = 9,
  parameter int LEN_RTRN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             last,
  output phase_e           ph_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept_evt,
  output logic             finish_evt,
  output logic             capture_evt,
  output logic             we_release_evt,
  output logic             ready
);
  phase_e ph;

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE: if (req_valid) ph_nxt = req_write ? PH_WSET : PH_RACC;
      PH_WSET: if (last) ph_nxt = PH_WSTB;
      PH_WSTB: if (last) ph_nxt = PH_WREC;
      PH_WREC: if (last) ph_nxt = PH_IDLE;
      PH_RACC: if (last) ph_nxt = PH_RTRN;
      PH_RTRN: if (last) ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (ph_nxt)
      PH_WSET: load_val = CNT_W'(LEN_WSET - 1);
      PH_WSTB: load_val = CNT_W'(LEN_WSTB - 1);
      PH_WREC: load_val = CNT_W'(LEN_WREC - 1);
      PH_RACC: load_val = CNT_W'(LEN_RACC - 1);
      PH_RTRN: load_val = CNT_W'(LEN_RTRN - 1);
      default: load_val = '0;
    endcase
  end

  assign load           = (ph_nxt != ph) && (ph_nxt != PH_IDLE);
  assign ready          = (ph == PH_IDLE);
  assign accept_evt     = ready && req_valid;
  assign capture_evt    = (ph == PH_RACC) && last;
  assign we_release_evt = (ph == PH_WSTB) && last;
  assign finish_evt     = ((ph == PH_WREC) || (ph == PH_RTRN)) && last;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else     ph <= ph_nxt;
  end
endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            ph_nxt,
  input  logic              accept_evt,
  input  logic              capture_evt,
  input  logic              we_release_evt,
  input  logic              finish_evt,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic sel_d, oe_d, we_d;

  always_comb begin
    sel_d = (ph_nxt == PH_WSET) || (ph_nxt == PH_WSTB) || (ph_nxt == PH_RACC);
    oe_d  = (ph_nxt == PH_RACC);
    we_d  = (ph_nxt == PH_WSTB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      mem_sel_n <= !sel_d;
      mem_sel   <= sel_d;
      mem_oe_n  <= !oe_d;
      mem_we_n  <= !we_d;
      done      <= finish_evt;
      if (accept_evt) begin
        mem_addr <= req_addr;
        dq_o     <= req_wdata;
      end
      if (accept_evt && req_write) dq_oe <= 1'b1;
      else if (we_release_evt)     dq_oe <= 1'b0;
      if (capture_evt) rdata <= dq_i;
    end
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int SPEED_GRADE = 0,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int LEN_WSET = wr_set_len(SPEED_GRADE, CLK_NS);
  localparam int LEN_WSTB = wr_stb_len(SPEED_GRADE, CLK_NS);
  localparam int LEN_WREC = wr_rec_len(SPEED_GRADE, CLK_NS);
  localparam int LEN_RACC = rd_acc_len(SPEED_GRADE, CLK_NS);
  localparam int LEN_RTRN = rd_trn_len(SPEED_GRADE, CLK_NS);
  localparam int LEN_MAX  = imax(imax(imax(LEN_WSET, LEN_WSTB), imax(LEN_WREC, LEN_RACC)),
                                 LEN_RTRN);
  localparam int CNT_W    = (LEN_MAX < 2) ? 1 : $clog2(LEN_MAX);

  phase_e            ph_nxt;
  logic              load, last;
  logic [CNT_W-1:0]  load_val;
  logic              accept_evt, finish_evt, capture_evt, we_release_evt;
  logic [DATA_W-1:0] dq_o;
  logic              dq_oe;

  sram_seq #(
    .CNT_W(CNT_W), .LEN_WSET(LEN_WSET), .LEN_WSTB(LEN_WSTB),
    .LEN_WREC(LEN_WREC), .LEN_RACC(LEN_RACC), .LEN_RTRN(LEN_RTRN)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .last(last), .ph_nxt(ph_nxt), .load(load), .load_val(load_val),
    .accept_evt(accept_evt), .finish_evt(finish_evt), .capture_evt(capture_evt),
    .we_release_evt(we_release_evt), .ready(req_ready)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .last(last)
  );

  sram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .ph_nxt(ph_nxt), .accept_evt(accept_evt),
    .capture_evt(capture_evt), .we_release_evt(we_release_evt),
    .finish_evt(finish_evt), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .dq_i(mem_dq), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .dq_o(dq_o), .dq_oe(dq_oe), .rdata(rsp_rdata),
    .done(rsp_done)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_dq
    assign mem_dq[b] = dq_oe ? dq_o[b] : 1'bz;
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe,
  input logic              accept_evt
);
  // R3
  sel_pair_chk: assert property (@(posedge clk) disable iff (rst)
    mem_sel_n == !mem_sel);
  // R2
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && mem_oe_n && mem_we_n));
  // R6
  we_window_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel_n && mem_oe_n));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(dq_o) && dq_oe));
  // R8
  drv_oe_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_oe_n);
  // R8
  drv_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !dq_oe);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> !req_ready);
endmodule

bind async_sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .dq_o(dq_o), .dq_oe(dq_oe),
  .accept_evt(accept_evt)
);

// File: tb/async_sram_ctrl_test.sv
module sram_bench_model #(
  parameter string NAME   = "fast",
  parameter int    EXP_WP = 6,
  parameter int    EXP_RA = 9,
  parameter int    EXP_AA = 9,
  parameter int    EXP_RT = 3
) (
  input  logic        clk,
  input  logic [15:0] a,
  input  logic        sel_n,
  input  logic        sel,
  input  logic        oe_n,
  input  logic        we_n,
  inout  wire  [7:0]  dq,
  output int          chk_n,
  output int          err_n
);
  logic [7:0] store [int];
  logic [7:0] dout = 8'h00;
  int c_n = 0, e_n = 0;
  int rd_cnt = 0, wr_cnt = 0, pre_cnt = 0, gap_cnt = 0;
  bit rd_prev = 0, wr_prev = 0, on_prev = 0, after_rd = 0;
  logic [15:0] w_a = '0;
  logic [7:0]  w_d = '0;

  wire on    = !sel_n && sel;
  wire rd_on = on && !oe_n && we_n;
  wire wr_on = on && !we_n;

  assign dq    = rd_on ? dout : 8'hzz;
  assign chk_n = c_n;
  assign err_n = e_n;

  function automatic logic [7:0] peek(input logic [15:0] x);
    return store.exists(int'(x)) ? store[int'(x)] : (x[7:0] ^ x[15:8] ^ 8'h3c);
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int exp);
    c_n++;
    if (!ok) begin
      e_n++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, NAME, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_on) begin
      rd_cnt++;
      dout = (rd_cnt >= EXP_AA) ? peek(a) : ~peek(a);
    end else if (rd_prev) begin
      note(rd_cnt == EXP_RA, "R4", "read access cycles", rd_cnt, EXP_RA);
      rd_cnt = 0; after_rd = 1; gap_cnt = 0;
    end
    if (wr_on) begin
      if (wr_cnt == 0) begin
        note(pre_cnt == 1, "R6", "write setup cycles", pre_cnt, 1);
        w_a = a; w_d = dq;
      end else begin
        note(a == w_a, "R6", "address during strobe", int'(a), int'(w_a));
        note(dq == w_d, "R6", "data during strobe", int'(dq), int'(w_d));
      end
      wr_cnt++;
    end else if (wr_prev) begin
      note(wr_cnt == EXP_WP, "R6", "write strobe cycles", wr_cnt, EXP_WP);
      store[int'(w_a)] = w_d;
      wr_cnt = 0;
    end
    if (on && we_n && oe_n) pre_cnt++;
    if (!on) begin
      pre_cnt = 0;
      gap_cnt++;
    end else if (!on_prev && after_rd) begin
      note(gap_cnt >= EXP_RT, "R5", "deselect after read", gap_cnt, EXP_RT);
      after_rd = 0;
    end
    rd_prev = rd_on; wr_prev = wr_on; on_prev = on;
  end
endmodule

module async_sram_ctrl_test;
  localparam int CLK_PERIOD = 10;

  // Bench restatement of the timing rules
  function automatic int b_ceil(input int ns);
    int c;
    c = ns / CLK_PERIOD;
    if (c * CLK_PERIOD < ns) c++;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int b_max(input int x, input int y);
    if (x >= y) return x;
    return y;
  endfunction
  function automatic int g_ns(input int g, input int fast, input int slow);
    return (g == 0) ? fast : slow;
  endfunction
  function automatic int b_ra(input int g);
    return b_max(b_ceil(g_ns(g, 85, 100)), b_ceil(g_ns(g, 45, 50)));
  endfunction
  function automatic int b_rt(input int g);
    return b_max(b_max(b_ceil(30), b_ceil(20)), b_ceil(g_ns(g, 85, 100)) - b_ra(g));
  endfunction
  function automatic int b_wp(input int g);
    return b_max(b_max(b_ceil(g_ns(g, 60, 70)), b_ceil(g_ns(g, 35, 40))),
                 b_ceil(g_ns(g, 70, 80)) - 1);
  endfunction
  function automatic int b_wr(input int g);
    return b_max(1, b_ceil(g_ns(g, 85, 100)) - 1 - b_wp(g));
  endfunction
  function automatic int exp_lat(input int g, input bit wr);
    return wr ? (1 + b_wp(g) + b_wr(g)) : (b_ra(g) + b_rt(g));
  endfunction

  logic clk = 0;
  logic rst = 1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rv [2];
  logic        rw [2];
  logic [15:0] ra [2];
  logic [7:0]  rwd [2];
  logic        rdy [2];
  logic [7:0]  rrd [2];
  logic        dn [2];
  logic [15:0] ma [2];
  logic        msn [2];
  logic        ms [2];
  logic        moe [2];
  logic        mwe [2];
  int          mc [2];
  int          me [2];
  wire  [7:0]  dq0, dq1;

  async_sram_ctrl #(.CLK_NS(CLK_PERIOD), .SPEED_GRADE(0)) uut (
    .clk(clk), .rst(rst), .req_valid(rv[0]), .req_write(rw[0]), .req_addr(ra[0]),
    .req_wdata(rwd[0]), .req_ready(rdy[0]), .rsp_rdata(rrd[0]), .rsp_done(dn[0]),
    .mem_addr(ma[0]), .mem_sel_n(msn[0]), .mem_sel(ms[0]), .mem_oe_n(moe[0]),
    .mem_we_n(mwe[0]), .mem_dq(dq0));
  async_sram_ctrl #(.CLK_NS(CLK_PERIOD), .SPEED_GRADE(1)) uut_slow (
    .clk(clk), .rst(rst), .req_valid(rv[1]), .req_write(rw[1]), .req_addr(ra[1]),
    .req_wdata(rwd[1]), .req_ready(rdy[1]), .rsp_rdata(rrd[1]), .rsp_done(dn[1]),
    .mem_addr(ma[1]), .mem_sel_n(msn[1]), .mem_sel(ms[1]), .mem_oe_n(moe[1]),
    .mem_we_n(mwe[1]), .mem_dq(dq1));

  sram_bench_model #(.NAME("fast"), .EXP_WP(b_wp(0)), .EXP_RA(b_ra(0)),
    .EXP_AA(b_ceil(85)), .EXP_RT(b_rt(0))) m_fast (
    .clk(clk), .a(ma[0]), .sel_n(msn[0]), .sel(ms[0]), .oe_n(moe[0]), .we_n(mwe[0]),
    .dq(dq0), .chk_n(mc[0]), .err_n(me[0]));
  sram_bench_model #(.NAME("slow"), .EXP_WP(b_wp(1)), .EXP_RA(b_ra(1)),
    .EXP_AA(b_ceil(100)), .EXP_RT(b_rt(1))) m_slow (
    .clk(clk), .a(ma[1]), .sel_n(msn[1]), .sel(ms[1]), .oe_n(moe[1]), .we_n(mwe[1]),
    .dq(dq1), .chk_n(mc[1]), .err_n(me[1]));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] shadow [int];

  function automatic logic [7:0] expect_at(input logic [15:0] x);
    if (shadow.exists(int'(x))) return shadow[int'(x)];
    return 8'h3c ^ x[15:8] ^ x[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               n_chk + mc[0] + mc[1], n_bad + me[0] + me[1]);
      $finish;
    end
  endtask

  task automatic run_op(input int u, input bit wr, input logic [15:0] a,
                        input logic [7:0] d, input bit poke,
                        output logic [7:0] rd, output int lat);
    @(negedge clk);
    rv[u] = 1; rw[u] = wr; ra[u] = a; rwd[u] = d;
    while (!rdy[u]) @(negedge clk);
    @(negedge clk);
    rv[u] = 0;
    lat = 0;
    if (poke) begin
      // R9: request raised while busy must be ignored
      rv[u] = 1; rw[u] = 1; ra[u] = a ^ 16'h5a5a; rwd[u] = ~d;
      @(negedge clk); lat++;
      @(negedge clk); lat++;
      rv[u] = 0;
    end
    while (!dn[u]) begin
      @(negedge clk);
      lat++;
    end
    rd = rrd[u];
    // R2: idle pins once done
    check(rdy[u] && msn[u] && !ms[u] && moe[u] && mwe[u], "R2", "idle pins at done",
          {msn[u], ms[u], moe[u], mwe[u]}, 4'b1011);
    @(negedge clk);
    // R9: one-cycle done
    check(!dn[u], "R9", "done width", int'(dn[u]), 0);
  endtask

  task automatic op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                    input bit poke);
    logic [7:0] r0, r1, e;
    int l0, l1;
    e = expect_at(a);
    fork
      run_op(0, wr, a, d, poke, r0, l0);
      run_op(1, wr, a, d, poke, r1, l1);
    join
    if (wr) begin
      check(l0 == exp_lat(0, 1), "R7", "fast write latency", l0, exp_lat(0, 1));
      check(l1 == exp_lat(1, 1), "R10", "slow write latency", l1, exp_lat(1, 1));
      shadow[int'(a)] = d;
    end else begin
      check(l0 == exp_lat(0, 0), "R5", "fast read latency", l0, exp_lat(0, 0));
      check(l1 == exp_lat(1, 0), "R10", "slow read latency", l1, exp_lat(1, 0));
      check(r0 == e, "R4", "fast read data", int'(r0), int'(e));
      check(r1 == e, "R4", "slow read data", int'(r1), int'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int u = 0; u < 2; u++) begin
      rv[u] = 0; rw[u] = 0; ra[u] = '0; rwd[u] = '0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state sampled while reset is held
    for (int u = 0; u < 2; u++) begin
      check(rdy[u] == 1, "R1", "ready in reset", int'(rdy[u]), 1);
      check(dn[u] == 0, "R1", "done in reset", int'(dn[u]), 0);
      check(msn[u] == 1 && ms[u] == 0, "R1", "selects in reset", {msn[u], ms[u]}, 2);
      check(moe[u] == 1 && mwe[u] == 1, "R1", "strobes in reset", {moe[u], mwe[u]}, 3);
    end
    rst = 0;
    @(negedge clk);
    for (int u = 0; u < 2; u++)
      check(msn[u] && !ms[u] && moe[u] && mwe[u], "R1", "pins after reset",
            {msn[u], ms[u], moe[u], mwe[u]}, 4'b1011);

    // Directed corners
    op(0, 16'h0000, 8'h00, 0);          // R4: unwritten location
    op(1, 16'h0000, 8'hff, 0);          // R6
    op(0, 16'h0000, 8'h00, 0);          // R4
    op(1, 16'hffff, 8'h00, 0);          // R6
    op(0, 16'hffff, 8'h00, 0);
    op(1, 16'h1234, 8'ha5, 1);          // R9: busy poke at 16'h1234^16'h5a5a
    op(0, 16'h1234 ^ 16'h5a5a, 8'h00, 0);  // R9: poke target unchanged
    op(0, 16'h1234, 8'h00, 0);
    op(1, 16'h0001, 8'h5a, 0);          // R8: write right after read turnaround
    op(0, 16'h0001, 8'h00, 0);

    // Random mix
    for (int i = 0; i < 80; i++) begin
      bit wr;
      logic [15:0] a;
      wr = 1'($urandom);
      if (($urandom % 4) == 0) a = 16'($urandom);
      else a = {12'h0a0, 4'($urandom)};
      op(wr, a, 8'($urandom), (i % 17) == 3);
    end
    repeat (3) @(negedge clk);
    report();
  end
endmodule